// File: doc/BRIEF.md
# Packet-granular payload FIFO controller

This block queues whole payloads rather than single words. A producer writes payload bytes one per cycle into a staging buffer. A commit command then turns the staged bytes into one stored entry. Each entry keeps its byte count, a 3-bit pipe tag and a no-acknowledge attribute. Up to three entries are held at a time, and each holds up to 32 bytes.

The consumer sees one head entry through a random-access byte port. It removes that entry with a transmit-done strobe. A retransmit-failure strobe leaves the head in place so the same payload can be sent again. A per-pipe "link lost" mask hides entries whose link has gone away. The head is the oldest entry whose pipe is still live, so entries for the same pipe always leave in write order. When every stored entry belongs to a lost pipe, the FIFO reports itself blocked and makes no progress until a flush empties it.

Top module: `pkt_fifo_ctrl`

## Requirements
- R1: After reset, `count` is 0, `empty` is 1, and `full`, `overflow`, `blocked` and `head_valid` are 0.
- R2: A commit stores the bytes staged since the previous commit or flush as one entry. Its length is the number of bytes staged, saturating at 32, and later bytes are dropped. Its pipe tag is `cmd_pipe`. Its no-acknowledge bit is 1 only for `cmd_kind` 1; kinds 0 (normal) and 2 (acknowledge payload) store 0. A byte written in the same cycle as a commit becomes byte 0 of the next payload.
- R3: A commit with no staged bytes is ignored and leaves `count` and `overflow` unchanged.
- R4: `full` is 1 when three entries are stored. A non-empty commit while full stores nothing, discards the staged bytes and sets the sticky `overflow` flag. That flag is cleared only by flush or reset.
- R5: The head is the oldest stored entry whose pipe has its `pipe_lost` bit at 0. A `tx_done` strobe removes exactly that entry, and the remaining entries keep their relative order.
- R6: `tx_done` with no visible head (empty or blocked) changes nothing.
- R7: `max_rt` keeps the head. When it is high in the same cycle as `tx_done`, no entry is removed.
- R8: `blocked` is 1 and `head_valid` is 0 when entries are stored but all of them are tagged to lost pipes.
- R9: `cmd_flush` empties the FIFO, clears the staging buffer and clears `overflow`. It takes priority over a commit or `tx_done` in the same cycle.
- R10: `rd_byte` returns byte `rd_idx` of the head entry without delay. `head_len`, `head_pipe`, `head_noack` and `rd_byte` read 0 when `head_valid` is 0.
- R11: `count` never exceeds 3. `empty` equals (`count` == 0) and `full` equals (`count` == 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Payload byte strobe into the staging buffer |
| wr_data | input | 8 | Payload byte |
| cmd_commit | input | 1 | Commit the staged bytes as one entry |
| cmd_kind | input | 2 | Commit kind: 0 normal, 1 no-acknowledge, 2 acknowledge payload |
| cmd_pipe | input | 3 | Pipe tag for the committed entry |
| cmd_flush | input | 1 | Discard all entries and staged bytes |
| tx_done | input | 1 | Head delivered; remove it |
| max_rt | input | 1 | Retransmit limit reached; keep the head |
| pipe_lost | input | 8 | One bit per pipe: link lost |
| rd_idx | input | 5 | Byte index into the head entry |
| head_valid | output | 1 | A deliverable head exists |
| head_len | output | 6 | Byte length of the head entry |
| head_pipe | output | 3 | Pipe tag of the head entry |
| head_noack | output | 1 | No-acknowledge attribute of the head entry |
| rd_byte | output | 8 | Head byte at `rd_idx` |
| count | output | 2 | Number of stored entries |
| full | output | 1 | Three entries stored |
| empty | output | 1 | No entries stored |
| blocked | output | 1 | Entries stored but none deliverable |
| overflow | output | 1 | Sticky: a commit was refused because the FIFO was full |

## Verification
The bench sweeps every payload length from 1 to 32 and then an over-long payload. A design that miscounts or fails to saturate would report the wrong `head_len` or corrupt bytes past the end. It fills the FIFO and commits once more: a design that overwrote the oldest slot, or kept the refused bytes staged, would show either a changed head or a phantom entry on the next empty commit. Lost-pipe masks are applied so that the head skips past an older entry, and then so that every entry is hidden. A design that popped in strict slot order, or compacted the remaining entries wrongly, would deliver the wrong pipe or lose write order. Retransmit failure raised together with `tx_done`, and flush raised together with commit and `tx_done`, check that the higher-priority event wins.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

  typedef enum logic [1:0] {
    KIND_NORMAL = 2'd0,
    KIND_NOACK  = 2'd1,
    KIND_ACKPLD = 2'd2
  } cmd_kind_e;

  // next staging length: grows by one until the payload limit
  function automatic int unsigned sat_inc(input int unsigned cur, input int unsigned lim);
    return (cur < lim) ? cur + 1 : lim;
  endfunction

  // only the no-acknowledge write kind marks the entry
  function automatic logic kind_noack(input logic [1:0] k);
    return k == KIND_NOACK;
  endfunction

endpackage

// File: rtl/pkt_fifo_stage.sv
module pkt_fifo_stage
  import pkt_fifo_pkg::*;
#(
  parameter int MAX_BYTES = 32,
  parameter int DATA_W    = 8,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int IDX_W    = $clog2(MAX_BYTES)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_valid,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic                               commit,
  input  logic                               flush,
  output logic [LEN_W-1:0]                   stg_len,
  output logic [MAX_BYTES-1:0][DATA_W-1:0]   stg_buf
);

  logic byte_room;
  assign byte_room = stg_len < LEN_W'(MAX_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_len <= '0;
    end else if (flush) begin
      stg_len <= '0;
    end else if (commit) begin
      // a byte arriving with the commit opens the next payload
      if (wr_valid) begin
        stg_buf[0] <= wr_data;
        stg_len    <= LEN_W'(1);
      end else begin
        stg_len    <= '0;
      end
    end else if (wr_valid && byte_room) begin
      stg_buf[stg_len[IDX_W-1:0]] <= wr_data;
      stg_len <= LEN_W'(sat_inc(int'(stg_len), MAX_BYTES));
    end
  end

  AST_STAGE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    stg_len <= LEN_W'(MAX_BYTES)); // R2

endmodule

// File: rtl/pkt_fifo_select.sv
module pkt_fifo_select #(
  parameter int DEPTH   = 3,
  parameter int PIPE_W  = 3,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NPIPE  = 1 << PIPE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0]              ent_valid,
  input  logic [DEPTH-1:0][PIPE_W-1:0]  ent_pipe,
  input  logic [NPIPE-1:0]              pipe_lost,
  output logic                          sel_valid,
  output logic [SLOT_W-1:0]             sel_idx
);

  logic [DEPTH-1:0] elig;

  for (genvar g = 0; g < DEPTH; g++) begin : g_elig
    assign elig[g] = ent_valid[g] && !pipe_lost[ent_pipe[g]];
  end

  // slot 0 is the oldest entry: lowest eligible slot wins
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        sel_valid = 1'b1;
        sel_idx   = SLOT_W'(i);
      end
    end
  end

  AST_SEL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (ent_valid[sel_idx] && !pipe_lost[ent_pipe[sel_idx]])); // R8

endmodule

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store #(
  parameter int DEPTH     = 3,
  parameter int MAX_BYTES = 32,
  parameter int DATA_W    = 8,
  parameter int PIPE_W    = 3,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int SLOT_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         flush,
  input  logic                                         push,
  input  logic [MAX_BYTES-1:0][DATA_W-1:0]             push_data,
  input  logic [LEN_W-1:0]                             push_len,
  input  logic [PIPE_W-1:0]                            push_pipe,
  input  logic                                         push_noack,
  input  logic                                         pop,
  input  logic [SLOT_W-1:0]                            pop_idx,
  output logic [DEPTH-1:0][MAX_BYTES-1:0][DATA_W-1:0]  mem,
  output logic [DEPTH-1:0][LEN_W-1:0]                  ent_len,
  output logic [DEPTH-1:0][PIPE_W-1:0]                 ent_pipe,
  output logic [DEPTH-1:0]                             ent_noack,
  output logic [DEPTH-1:0]                             ent_valid,
  output logic [CNT_W-1:0]                             cnt
);

  logic [DEPTH-1:0][MAX_BYTES-1:0][DATA_W-1:0] n_mem;
  logic [DEPTH-1:0][LEN_W-1:0]                 n_len;
  logic [DEPTH-1:0][PIPE_W-1:0]                n_pipe;
  logic [DEPTH-1:0]                            n_noack;
  logic [CNT_W-1:0]                            n_cnt;

  for (genvar g = 0; g < DEPTH; g++) begin : g_valid
    assign ent_valid[g] = cnt > CNT_W'(g);
  end

  // removal compacts younger entries down one slot, then a push
  // lands right after the last surviving entry
  always_comb begin
    n_mem   = mem;
    n_len   = ent_len;
    n_pipe  = ent_pipe;
    n_noack = ent_noack;
    n_cnt   = cnt;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(pop_idx)) begin
          n_mem[i]   = mem[i+1];
          n_len[i]   = ent_len[i+1];
          n_pipe[i]  = ent_pipe[i+1];
          n_noack[i] = ent_noack[i+1];
        end
      end
      n_cnt = cnt - CNT_W'(1);
    end
    if (push) begin
      n_mem[SLOT_W'(n_cnt)]   = push_data;
      n_len[SLOT_W'(n_cnt)]   = push_len;
      n_pipe[SLOT_W'(n_cnt)]  = push_pipe;
      n_noack[SLOT_W'(n_cnt)] = push_noack;
      n_cnt = n_cnt + CNT_W'(1);
    end
    if (flush) begin
      n_cnt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      ent_len   <= '0;
      ent_pipe  <= '0;
      ent_noack <= '0;
    end else begin
      cnt       <= n_cnt;
      ent_len   <= n_len;
      ent_pipe  <= n_pipe;
      ent_noack <= n_noack;
    end
    mem <= n_mem;
  end

  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R11

  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt < CNT_W'(DEPTH))); // R4

endmodule

// File: rtl/pkt_fifo_ctrl.sv
module pkt_fifo_ctrl
  import pkt_fifo_pkg::*;
#(
  parameter int DEPTH     = 3,
  parameter int MAX_BYTES = 32,
  parameter int DATA_W    = 8,
  parameter int PIPE_W    = 3,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int IDX_W    = $clog2(MAX_BYTES),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int SLOT_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NPIPE    = 1 << PIPE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_commit,
  input  logic [1:0]        cmd_kind,
  input  logic [PIPE_W-1:0] cmd_pipe,
  input  logic              cmd_flush,
  input  logic              tx_done,
  input  logic              max_rt,
  input  logic [NPIPE-1:0]  pipe_lost,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              head_valid,
  output logic [LEN_W-1:0]  head_len,
  output logic [PIPE_W-1:0] head_pipe,
  output logic              head_noack,
  output logic [DATA_W-1:0] rd_byte,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              blocked,
  output logic              overflow
);

  logic [LEN_W-1:0]                            stg_len;
  logic [MAX_BYTES-1:0][DATA_W-1:0]            stg_buf;
  logic [DEPTH-1:0][MAX_BYTES-1:0][DATA_W-1:0] mem;
  logic [DEPTH-1:0][LEN_W-1:0]                 ent_len;
  logic [DEPTH-1:0][PIPE_W-1:0]                ent_pipe;
  logic [DEPTH-1:0]                            ent_noack;
  logic [DEPTH-1:0]                            ent_valid;
  logic [CNT_W-1:0]                            cnt;
  logic                                        sel_valid;
  logic [SLOT_W-1:0]                           sel_idx;

  // named events for the checks below
  logic ev_commit_live;
  logic ev_accept;
  logic ev_reject;
  logic ev_remove;

  assign full           = cnt == CNT_W'(DEPTH);
  assign empty          = cnt == '0;
  assign ev_commit_live = cmd_commit && !cmd_flush && (stg_len != '0);
  assign ev_accept      = ev_commit_live && !full;
  assign ev_reject      = ev_commit_live && full;
  assign ev_remove      = tx_done && !max_rt && !cmd_flush && sel_valid;

  pkt_fifo_stage #(
    .MAX_BYTES (MAX_BYTES),
    .DATA_W    (DATA_W)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .commit   (cmd_commit),
    .flush    (cmd_flush),
    .stg_len  (stg_len),
    .stg_buf  (stg_buf)
  );

  pkt_fifo_store #(
    .DEPTH     (DEPTH),
    .MAX_BYTES (MAX_BYTES),
    .DATA_W    (DATA_W),
    .PIPE_W    (PIPE_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (cmd_flush),
    .push       (ev_accept),
    .push_data  (stg_buf),
    .push_len   (stg_len),
    .push_pipe  (cmd_pipe),
    .push_noack (kind_noack(cmd_kind)),
    .pop        (ev_remove),
    .pop_idx    (sel_idx),
    .mem        (mem),
    .ent_len    (ent_len),
    .ent_pipe   (ent_pipe),
    .ent_noack  (ent_noack),
    .ent_valid  (ent_valid),
    .cnt        (cnt)
  );

  pkt_fifo_select #(
    .DEPTH  (DEPTH),
    .PIPE_W (PIPE_W)
  ) u_select (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_valid (ent_valid),
    .ent_pipe  (ent_pipe),
    .pipe_lost (pipe_lost),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflow <= 1'b0;
    end else if (cmd_flush) begin
      overflow <= 1'b0;
    end else if (ev_reject) begin
      overflow <= 1'b1;
    end
  end

  assign count      = cnt;
  assign blocked    = !empty && !sel_valid;
  assign head_valid = sel_valid;
  assign head_len   = sel_valid ? ent_len[sel_idx]       : '0;
  assign head_pipe  = sel_valid ? ent_pipe[sel_idx]      : '0;
  assign head_noack = sel_valid ? ent_noack[sel_idx]     : 1'b0;
  assign rd_byte    = sel_valid ? mem[sel_idx][rd_idx]   : '0;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flush |=> (count == '0 && !overflow)); // R9

  AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (overflow && count == $past(count))); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !cmd_flush) |=> overflow); // R4

  AST_RETRY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (max_rt && !cmd_flush && !ev_accept) |=> count == $past(count)); // R7

  AST_REMOVE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && head_valid && !max_rt && !cmd_flush && !ev_accept)
      |=> count == $past(count) - CNT_W'(1)); // R5

  AST_IDLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !head_valid && !cmd_flush && !ev_accept)
      |=> count == $past(count)); // R6

  AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_commit && !cmd_flush && stg_len == '0 && !tx_done)
      |=> (count == $past(count) && overflow == $past(overflow))); // R3

endmodule

// File: tb/pkt_fifo_ctrl_tb.sv
`timescale 1ns/100ps
module pkt_fifo_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cmd_commit = 1'b0;
  logic [1:0] cmd_kind = '0;
  logic [2:0] cmd_pipe = '0;
  logic       cmd_flush = 1'b0;
  logic       tx_done = 1'b0;
  logic       max_rt = 1'b0;
  logic [7:0] pipe_lost = '0;
  logic [4:0] rd_idx = '0;
  logic       head_valid;
  logic [5:0] head_len;
  logic [2:0] head_pipe;
  logic       head_noack;
  logic [7:0] rd_byte;
  logic [1:0] count;
  logic       full, empty, blocked, overflow;

  pkt_fifo_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .cmd_commit(cmd_commit), .cmd_kind(cmd_kind), .cmd_pipe(cmd_pipe),
    .cmd_flush(cmd_flush), .tx_done(tx_done), .max_rt(max_rt),
    .pipe_lost(pipe_lost), .rd_idx(rd_idx), .head_valid(head_valid),
    .head_len(head_len), .head_pipe(head_pipe), .head_noack(head_noack),
    .rd_byte(rd_byte), .count(count), .full(full), .empty(empty),
    .blocked(blocked), .overflow(overflow)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // bench model of the FIFO contents
  int q_len[$], q_pipe[$], q_na[$], q_seed[$];
  int m_stg = 0, m_seed = 0, m_ovf = 0;

  function automatic int pbyte(int seed, int i);
    return (seed * 37 + i * 11 + 3) & 255;
  endfunction

  task automatic chk(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(int len, int seed, int start);
    for (int i = 0; i < len; i++) begin
      wr_valid = 1'b1;
      wr_data  = 8'(pbyte(seed, start + i));
      tick();
    end
    wr_valid = 1'b0;
    m_seed = seed;
    m_stg  = (m_stg + len > 32) ? 32 : m_stg + len;
  endtask

  task automatic model_commit(int kind, int pipe);
    if (m_stg > 0) begin
      if (q_len.size() >= 3) m_ovf = 1;
      else begin
        q_len.push_back(m_stg); q_pipe.push_back(pipe);
        q_na.push_back(kind == 1 ? 1 : 0); q_seed.push_back(m_seed);
      end
    end
    m_stg = 0;
  endtask

  task automatic commit(int kind, int pipe);
    cmd_commit = 1'b1; cmd_kind = 2'(kind); cmd_pipe = 3'(pipe);
    tick();
    cmd_commit = 1'b0;
    model_commit(kind, pipe);
  endtask

  function automatic int model_head();
    for (int i = 0; i < q_len.size(); i++)
      if (!pipe_lost[q_pipe[i]]) return i;
    return -1;
  endfunction

  task automatic pop(bit mr);
    int h;
    h = model_head();
    tx_done = 1'b1; max_rt = mr;
    tick();
    tx_done = 1'b0; max_rt = 1'b0;
    if (!mr && h >= 0) begin
      q_len.delete(h); q_pipe.delete(h); q_na.delete(h); q_seed.delete(h);
    end
  endtask

  task automatic flush();
    cmd_flush = 1'b1;
    tick();
    cmd_flush = 1'b0;
    q_len.delete(); q_pipe.delete(); q_na.delete(); q_seed.delete();
    m_stg = 0; m_ovf = 0;
  endtask

  task automatic check_state(string rq);
    int h, n, bad;
    h = model_head();
    n = q_len.size();
    chk("R11", {rq, " count"}, int'(count), n);
    chk("R11", {rq, " full"}, int'(full), n == 3);
    chk("R11", {rq, " empty"}, int'(empty), n == 0);
    chk("R4", {rq, " overflow"}, int'(overflow), m_ovf);
    chk("R8", {rq, " blocked"}, int'(blocked), (n > 0) && (h < 0));
    chk(rq, "head_valid", int'(head_valid), h >= 0);
    if (h >= 0) begin
      chk("R2", {rq, " head_len"}, int'(head_len), q_len[h]);
      chk("R2", {rq, " head_pipe"}, int'(head_pipe), q_pipe[h]);
      chk("R2", {rq, " head_noack"}, int'(head_noack), q_na[h]);
      bad = 0;
      for (int i = 0; i < q_len[h]; i++) begin
        rd_idx = 5'(i);
        #0.1;
        if (int'(rd_byte) != pbyte(q_seed[h], i)) bad++;
      end
      chk("R10", {rq, " byte mismatches"}, bad, 0);
    end else begin
      chk("R10", {rq, " idle head_len"}, int'(head_len), 0);
      chk("R10", {rq, " idle rd_byte"}, int'(rd_byte), 0);
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check_state("R1");

    // R2 R10: every length 1..32, each kind, pushed then removed
    for (int len = 1; len <= 32; len++) begin
      load(len, len, 0);
      commit(len % 3, len % 8);
      check_state("R2");
      pop(1'b0);
      check_state("R5");
    end

    // R2: bytes past 32 are dropped
    load(35, 90, 0);
    commit(1, 6);
    check_state("R2");
    pop(1'b0);

    // R2: byte written with the commit opens the next payload
    load(2, 50, 0);
    m_stg = 2;
    wr_valid = 1'b1; wr_data = 8'(pbyte(51, 0)); cmd_commit = 1'b1;
    cmd_kind = 2'd0; cmd_pipe = 3'd4;
    tick();
    wr_valid = 1'b0; cmd_commit = 1'b0;
    model_commit(0, 4);
    m_stg = 1;
    load(2, 51, 1);
    commit(2, 5);
    check_state("R2");
    pop(1'b0);
    check_state("R2");
    pop(1'b0);

    // R3: commit with nothing staged
    commit(0, 1);
    check_state("R3");

    // R4: fill, then one more commit
    load(3, 60, 0); commit(0, 1);
    load(4, 61, 0); commit(1, 2);
    load(5, 62, 0); commit(2, 3);
    check_state("R4");
    load(6, 63, 0); commit(0, 4);
    check_state("R4");
    pop(1'b0);
    commit(0, 4);           // refused bytes must not remain staged
    check_state("R4");

    // R5: remaining order
    pop(1'b0); check_state("R5");
    pop(1'b0); check_state("R5");

    // R6: removal on empty
    pop(1'b0); check_state("R6");

    // R7: retransmit failure keeps the head
    load(7, 70, 0); commit(0, 0);
    load(8, 71, 0); commit(0, 0);
    pop(1'b1); check_state("R7");
    max_rt = 1'b1; tick(); max_rt = 1'b0;
    check_state("R7");
    flush(); check_state("R9");

    // R5 R8: lost pipes skip the oldest entries, same-pipe order kept
    load(4, 80, 0); commit(0, 1);
    load(5, 81, 0); commit(2, 2);
    load(6, 82, 0); commit(1, 1);
    pipe_lost = 8'b0000_0010;
    #0.1;
    check_state("R8");
    pop(1'b0); check_state("R5");
    check_state("R8");
    pop(1'b0); check_state("R6");
    pipe_lost = 8'h00;
    #0.1;
    check_state("R5");
    pop(1'b0); check_state("R5");
    pipe_lost = 8'hFF;
    #0.1;
    check_state("R8");

    // R9: flush beats commit and removal; also clears overflow
    load(2, 85, 0); commit(0, 3);
    load(2, 86, 0); commit(0, 3);
    load(2, 87, 0); commit(0, 3);   // refused: overflow
    pipe_lost = 8'h00;
    load(3, 88, 0);
    cmd_flush = 1'b1; cmd_commit = 1'b1; tx_done = 1'b1;
    tick();
    cmd_flush = 1'b0; cmd_commit = 1'b0; tx_done = 1'b0;
    q_len.delete(); q_pipe.delete(); q_na.delete(); q_seed.delete();
    m_stg = 0; m_ovf = 0;
    check_state("R9");
    commit(0, 3);
    check_state("R9");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule